// File: doc/BRIEF.md
# Dual-Port Banked Scratchpad Access Arbiter

This block sits between a scatter/gather load-store unit and a tightly-coupled data memory built from word-interleaved single-port banks. The unit may present two independent load or store requests per cycle, each one word wide or narrower. The arbiter decodes each request's bank and word, drives the bank interfaces, and grants both requests in the same cycle whenever the memory can serve them together. When it cannot, it holds one request back through its ready signal.

Two requests that land in different banks always go together. Two requests that land in one bank but on different words cannot both be served, so port 0 goes first and port 1 waits. Two requests to the very same word share a single bank access. Stores are merged byte by byte in that case, and a load paired with a store sees the word as it was before the store. A load to a bank that took a store in the previous cycle is held back for one cycle. Load data comes back on the requesting port one cycle after the grant. The bank arrays are external. Each bank performs its strobed write and returns the prior contents of the addressed word one cycle after an enabled access.

Top module: `tcm_dual_arb`

## Requirements
- R1: The bank of a request is address bits [3:2]. The word index presented to that bank is the address bits above bit 3. Address bits [1:0] affect neither.
- R2: Two valid requests to different banks are both granted (ready high) in the same cycle, unless R7 holds one back. At most two bank enables are active in any cycle.
- R3: When port 0 and port 1 target different words of the same bank, port 0 is granted and port 1 sees ready low. A port-1 request that is held until the next cycle is then granted. A port-0 store is never stalled.
- R4: Two requests to the same word of the same bank are both granted in one cycle through a single bank access. Two loads paired this way return the same word.
- R5: Two stores paired as in R4 write the union of their byte strobes. On a byte that both ports enable, port 1's data is written (strobe bit i covers data bits 8i+7:8i).
- R6: A load paired with a store as in R4 returns the word's contents from before the store, and the store takes effect.
- R7: A load whose bank received a granted store in the previous cycle sees ready low for exactly that one cycle. A load to a different bank in the same cycle is not held back.
- R8: A granted load raises that port's rvalid exactly one cycle later, with the bank's word on rdata. A granted store raises no rvalid.
- R9: After reset no rvalid and no bank enable is asserted while no request is valid, and the first load after reset is not held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p0_valid | input | 1 | Port 0 request valid |
| p0_ready | output | 1 | Port 0 request granted this cycle |
| p0_addr | input | ADDR_W | Port 0 byte address |
| p0_we | input | 1 | Port 0 store (1) or load (0) |
| p0_be | input | DATA_W/8 | Port 0 byte strobes |
| p0_wdata | input | DATA_W | Port 0 store data |
| p0_rvalid | output | 1 | Port 0 load data valid |
| p0_rdata | output | DATA_W | Port 0 load data |
| p1_valid | input | 1 | Port 1 request valid |
| p1_ready | output | 1 | Port 1 request granted this cycle |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_we | input | 1 | Port 1 store (1) or load (0) |
| p1_be | input | DATA_W/8 | Port 1 byte strobes |
| p1_wdata | input | DATA_W | Port 1 store data |
| p1_rvalid | output | 1 | Port 1 load data valid |
| p1_rdata | output | DATA_W | Port 1 load data |
| bk_en | output | NBANK | Per-bank access enable |
| bk_we | output | NBANK | Per-bank write enable |
| bk_be | output | NBANK*DATA_W/8 | Per-bank byte write strobes |
| bk_idx | output | NBANK*(ADDR_W-2-log2 NBANK) | Per-bank word index |
| bk_wdata | output | NBANK*DATA_W | Per-bank write data |
| bk_rdata | input | NBANK*DATA_W | Per-bank read data, prior contents one cycle after enable |

## Verification
The in-RTL assertions watch, on every cycle, the grant rules at the ports: stores to separate banks or to one shared word always go together, no two granted requests ever open different words of one bank, port 0 stores never stall, a load never follows a store into the same bank on the next cycle, rvalid tracks granted loads exactly, and the bank enable count stays at or below two. What those properties cannot show is data content: the byte merge with port 1 winning overlaps, the old word seen by a load paired with a store, the index and bank decoding against a real memory, and a stalled port-1 request completing afterwards. The directed scenarios show these against a bench memory model.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;
   // byte offset within a 32-bit word sits below the bank select
   localparam int unsigned WORD_OFS_BITS = 2;
   localparam int unsigned LANE_W        = 8;
   localparam int unsigned NUM_PORTS     = 2;
endpackage

// File: rtl/tcm_arb_req_dec.sv
module tcm_arb_req_dec
   import tcm_arb_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned BANK_W = 2,
   parameter int unsigned IDX_W  = ADDR_W - WORD_OFS_BITS - BANK_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [IDX_W-1:0]  idx
);
   logic unused_ofs;

   assign bank       = addr[WORD_OFS_BITS +: BANK_W];
   assign idx        = addr[WORD_OFS_BITS + BANK_W +: IDX_W];
   assign unused_ofs = ^addr[WORD_OFS_BITS-1:0];
endmodule

// File: rtl/tcm_arb_bank_port.sv
module tcm_arb_bank_port
   import tcm_arb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 8,
   localparam int unsigned STRB_W = DATA_W / LANE_W
) (
   input  logic              hit0,
   input  logic              hit1,
   input  logic              we0,
   input  logic              we1,
   input  logic [STRB_W-1:0] be0,
   input  logic [STRB_W-1:0] be1,
   input  logic [IDX_W-1:0]  idx0,
   input  logic [IDX_W-1:0]  idx1,
   input  logic [DATA_W-1:0] wd0,
   input  logic [DATA_W-1:0] wd1,
   output logic              en,
   output logic              we,
   output logic [STRB_W-1:0] be,
   output logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] wdata
);
   logic st0, st1;

   assign st0 = hit0 & we0;
   assign st1 = hit1 & we1;
   assign en  = hit0 | hit1;
   assign we  = st0 | st1;
   // both hits on one bank only happen for the same word
   assign idx = hit0 ? idx0 : idx1;

   for (genvar ln = 0; ln < STRB_W; ln++) begin : g_lane
      logic take0, take1;
      assign take0 = st0 & be0[ln];
      assign take1 = st1 & be1[ln];
      assign be[ln] = take0 | take1;
      assign wdata[ln*LANE_W +: LANE_W] = take1 ? wd1[ln*LANE_W +: LANE_W]
                                                : wd0[ln*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/tcm_arb_rd_ret.sv
module tcm_arb_rd_ret #(
   parameter int unsigned NBANK  = 4,
   parameter int unsigned BANK_W = 2,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic [BANK_W-1:0]       bank,
   input  logic [NBANK*DATA_W-1:0] bk_rdata,
   output logic                    rvalid,
   output logic [DATA_W-1:0]       rdata
);
   logic [BANK_W-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         bank_q <= '0;
      end else begin
         rvalid <= take;
         if (take) bank_q <= bank;
      end
   end

   assign rdata = bk_rdata[int'(bank_q)*DATA_W +: DATA_W];
endmodule

// File: rtl/tcm_dual_arb.sv
module tcm_dual_arb
   import tcm_arb_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NBANK  = 4,
   localparam int unsigned BANK_W = $clog2(NBANK),
   localparam int unsigned IDX_W  = ADDR_W - WORD_OFS_BITS - BANK_W,
   localparam int unsigned STRB_W = DATA_W / LANE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    p0_valid,
   output logic                    p0_ready,
   input  logic [ADDR_W-1:0]       p0_addr,
   input  logic                    p0_we,
   input  logic [STRB_W-1:0]       p0_be,
   input  logic [DATA_W-1:0]       p0_wdata,
   output logic                    p0_rvalid,
   output logic [DATA_W-1:0]       p0_rdata,
   input  logic                    p1_valid,
   output logic                    p1_ready,
   input  logic [ADDR_W-1:0]       p1_addr,
   input  logic                    p1_we,
   input  logic [STRB_W-1:0]       p1_be,
   input  logic [DATA_W-1:0]       p1_wdata,
   output logic                    p1_rvalid,
   output logic [DATA_W-1:0]       p1_rdata,
   output logic [NBANK-1:0]        bk_en,
   output logic [NBANK-1:0]        bk_we,
   output logic [NBANK*STRB_W-1:0] bk_be,
   output logic [NBANK*IDX_W-1:0]  bk_idx,
   output logic [NBANK*DATA_W-1:0] bk_wdata,
   input  logic [NBANK*DATA_W-1:0] bk_rdata
);
   // ---------------- elaboration checks ----------------
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if (DATA_W % LANE_W != 0 || DATA_W > 32 || DATA_W < LANE_W) begin : g_bad_data
      $error("DATA_W must be 8, 16, 24 or 32");
   end
   if (ADDR_W <= WORD_OFS_BITS + BANK_W) begin : g_bad_addr
      $error("ADDR_W leaves no word index bits");
   end

   // ---------------- request decode ----------------
   logic [ADDR_W-1:0] addr_v [NUM_PORTS];
   logic [BANK_W-1:0] bank_v [NUM_PORTS];
   logic [IDX_W-1:0]  idx_v  [NUM_PORTS];

   assign addr_v[0] = p0_addr;
   assign addr_v[1] = p1_addr;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
      tcm_arb_req_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) dec_i (
         .addr (addr_v[p]),
         .bank (bank_v[p]),
         .idx  (idx_v[p])
      );
   end

   // ---------------- grant logic ----------------
   logic [NBANK-1:0] st_q, st_d;
   logic raw0, raw1, clash, g0, g1;

   assign raw0  = p0_valid & ~p0_we & st_q[bank_v[0]];
   assign raw1  = p1_valid & ~p1_we & st_q[bank_v[1]];
   assign g0    = p0_valid & ~raw0;
   assign clash = g0 & (bank_v[1] == bank_v[0]) & (idx_v[1] != idx_v[0]);
   assign g1    = p1_valid & ~raw1 & ~clash;

   assign p0_ready = g0;
   assign p1_ready = g1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   // ---------------- per-bank drive ----------------
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit0, hit1;
      assign hit0 = g0 & (bank_v[0] == BANK_W'(b));
      assign hit1 = g1 & (bank_v[1] == BANK_W'(b));
      assign st_d[b] = (hit0 & p0_we) | (hit1 & p1_we);

      tcm_arb_bank_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) bp_i (
         .hit0  (hit0),
         .hit1  (hit1),
         .we0   (p0_we),
         .we1   (p1_we),
         .be0   (p0_be),
         .be1   (p1_be),
         .idx0  (idx_v[0]),
         .idx1  (idx_v[1]),
         .wd0   (p0_wdata),
         .wd1   (p1_wdata),
         .en    (bk_en[b]),
         .we    (bk_we[b]),
         .be    (bk_be[b*STRB_W +: STRB_W]),
         .idx   (bk_idx[b*IDX_W +: IDX_W]),
         .wdata (bk_wdata[b*DATA_W +: DATA_W])
      );
   end

   // ---------------- read return ----------------
   tcm_arb_rd_ret #(.NBANK(NBANK), .BANK_W(BANK_W), .DATA_W(DATA_W)) ret0_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (g0 & ~p0_we),
      .bank     (bank_v[0]),
      .bk_rdata (bk_rdata),
      .rvalid   (p0_rvalid),
      .rdata    (p0_rdata)
   );

   tcm_arb_rd_ret #(.NBANK(NBANK), .BANK_W(BANK_W), .DATA_W(DATA_W)) ret1_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (g1 & ~p1_we),
      .bank     (bank_v[1]),
      .bk_rdata (bk_rdata),
      .rvalid   (p1_rvalid),
      .rdata    (p1_rdata)
   );

   // ---------------- assertions ----------------
   AST_SPLIT_STORES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p1_valid && p0_we && p1_we && p0_addr[3:2] != p1_addr[3:2])
      |-> (p0_ready && p1_ready)); // R2

   AST_BANK_LOAD_MAX2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bk_en) <= 2); // R2

   AST_NO_WORD_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p0_ready && p1_valid && p1_ready && p0_addr[3:2] == p1_addr[3:2])
      |-> (p0_addr[ADDR_W-1:4] == p1_addr[ADDR_W-1:4])); // R3

   AST_P0_STORE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p0_we) |-> p0_ready); // R3

   AST_SAME_WORD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p1_valid && p0_we && p1_we && p0_addr[ADDR_W-1:2] == p1_addr[ADDR_W-1:2])
      |-> (p0_ready && p1_ready)); // R4

   AST_RAW_HOLD_P0: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p0_ready && p0_we)
      |=> !(p0_valid && !p0_we && p0_ready && p0_addr[3:2] == $past(p0_addr[3:2]))); // R7

   AST_RAW_HOLD_P1: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p0_ready && p0_we)
      |=> !(p1_valid && !p1_we && p1_ready && p1_addr[3:2] == $past(p0_addr[3:2]))); // R7

   AST_RVALID_P0: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p0_ready && !p0_we) |=> p0_rvalid); // R8

   AST_NO_SPURIOUS_P0: assert property (@(posedge clk) disable iff (!rst_n)
      !(p0_valid && p0_ready && !p0_we) |=> !p0_rvalid); // R8

   AST_RVALID_P1: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_valid && p1_ready && !p1_we) |=> p1_rvalid); // R8

   AST_NO_SPURIOUS_P1: assert property (@(posedge clk) disable iff (!rst_n)
      !(p1_valid && p1_ready && !p1_we) |=> !p1_rvalid); // R8
endmodule

// File: tb/tcm_dual_arb_tb_top.sv
`timescale 1ns/1ps
module tcm_dual_arb_tb_top;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int NB = 4;
   localparam int SW = 4;
   localparam int IW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          p0_valid, p0_ready, p0_we, p0_rvalid;
   logic [AW-1:0] p0_addr;
   logic [SW-1:0] p0_be;
   logic [DW-1:0] p0_wdata, p0_rdata;
   logic          p1_valid, p1_ready, p1_we, p1_rvalid;
   logic [AW-1:0] p1_addr;
   logic [SW-1:0] p1_be;
   logic [DW-1:0] p1_wdata, p1_rdata;
   logic [NB-1:0]    bk_en, bk_we;
   logic [NB*SW-1:0] bk_be;
   logic [NB*IW-1:0] bk_idx;
   logic [NB*DW-1:0] bk_wdata, bk_rdata;

   int checks = 0;
   int failures = 0;

   tcm_dual_arb #(.ADDR_W(AW), .DATA_W(DW), .NBANK(NB)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_addr(p0_addr), .p0_we(p0_we),
      .p0_be(p0_be), .p0_wdata(p0_wdata), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
      .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_addr(p1_addr), .p1_we(p1_we),
      .p1_be(p1_be), .p1_wdata(p1_wdata), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
      .bk_en(bk_en), .bk_we(bk_we), .bk_be(bk_be), .bk_idx(bk_idx),
      .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
   );

   // initial word content of bank b, index i
   function automatic logic [31:0] pre(int b, int i);
      return 32'hB000_0000 | (b << 16) | i;
   endfunction

   // bank memory model: read-first, strobed write
   logic [31:0] mem [NB][1<<IW];
   logic [31:0] rdq [NB];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++)
            for (int i = 0; i < (1<<IW); i++) mem[b][i] <= pre(b, i);
      end else begin
         for (int b = 0; b < NB; b++) begin
            if (bk_en[b]) begin
               rdq[b] <= mem[b][bk_idx[b*IW +: IW]];
               if (bk_we[b])
                  for (int k = 0; k < SW; k++)
                     if (bk_be[b*SW+k])
                        mem[b][bk_idx[b*IW +: IW]][k*8 +: 8] <= bk_wdata[b*DW + k*8 +: 8];
            end
         end
      end
   end

   always_comb
      for (int b = 0; b < NB; b++) bk_rdata[b*DW +: DW] = rdq[b];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drv0(input logic v, input logic [AW-1:0] a, input logic we,
                       input logic [SW-1:0] be, input logic [DW-1:0] d);
      p0_valid = v; p0_addr = a; p0_we = we; p0_be = be; p0_wdata = d;
   endtask

   task automatic drv1(input logic v, input logic [AW-1:0] a, input logic we,
                       input logic [SW-1:0] be, input logic [DW-1:0] d);
      p1_valid = v; p1_addr = a; p1_we = we; p1_be = be; p1_wdata = d;
   endtask

   task automatic idle();
      drv0(1'b0, '0, 1'b0, '0, '0);
      drv1(1'b0, '0, 1'b0, '0, '0);
   endtask

   // one clock: from just after a falling edge to the next falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R9", "p0_rvalid after reset", 32'(p0_rvalid), 32'd0);
      chk("R9", "p1_rvalid after reset", 32'(p1_rvalid), 32'd0);
      chk("R9", "bk_en idle", 32'(bk_en), 32'd0);
      drv0(1'b1, 12'h020, 1'b0, 4'hF, '0);
      #1;
      chk("R9", "first load ready", 32'(p0_ready), 32'd1);
      step();
      idle();
      chk("R9", "first load data", p0_rdata, pre(0, 2));
      step();
   endtask

   task automatic t_diff_banks();
      drv0(1'b1, 12'h010, 1'b0, 4'hF, '0);   // bank 0, word 1
      drv1(1'b1, 12'h027, 1'b0, 4'hF, '0);   // bank 1, word 2, offset 3
      #1;
      chk("R2", "p0_ready split", 32'(p0_ready), 32'd1);
      chk("R2", "p1_ready split", 32'(p1_ready), 32'd1);
      chk("R1", "bank enables", 32'(bk_en), 32'h3);
      chk("R1", "bank1 index", 32'(bk_idx[1*IW +: IW]), 32'd2);
      chk("R1", "bank0 index", 32'(bk_idx[0*IW +: IW]), 32'd1);
      step();
      idle();
      chk("R8", "p0_rvalid", 32'(p0_rvalid), 32'd1);
      chk("R8", "p1_rvalid", 32'(p1_rvalid), 32'd1);
      chk("R2", "p0 data", p0_rdata, pre(0, 1));
      chk("R1", "p1 data", p1_rdata, pre(1, 2));
      step();
   endtask

   task automatic t_conflict();
      drv0(1'b1, 12'h000, 1'b0, 4'hF, '0);   // bank 0, word 0
      drv1(1'b1, 12'h010, 1'b0, 4'hF, '0);   // bank 0, word 1
      #1;
      chk("R3", "p0 wins", 32'(p0_ready), 32'd1);
      chk("R3", "p1 stalled", 32'(p1_ready), 32'd0);
      step();
      drv0(1'b0, '0, 1'b0, '0, '0);
      chk("R3", "p0 data", p0_rdata, pre(0, 0));
      chk("R3", "no p1 rvalid while stalled", 32'(p1_rvalid), 32'd0);
      #1;
      chk("R3", "p1 granted next", 32'(p1_ready), 32'd1);
      step();
      idle();
      chk("R3", "p1 rvalid later", 32'(p1_rvalid), 32'd1);
      chk("R3", "p1 data later", p1_rdata, pre(0, 1));
      step();
   endtask

   task automatic t_same_word_reads();
      drv0(1'b1, 12'h034, 1'b0, 4'hF, '0);   // bank 1, word 3
      drv1(1'b1, 12'h034, 1'b0, 4'hF, '0);
      #1;
      chk("R4", "both ready", 32'({p0_ready, p1_ready}), 32'h3);
      chk("R4", "single bank access", 32'(bk_en), 32'h2);
      step();
      idle();
      chk("R4", "p0 data", p0_rdata, pre(1, 3));
      chk("R4", "p1 data", p1_rdata, pre(1, 3));
      step();
   endtask

   task automatic t_merge_writes();
      drv0(1'b1, 12'h048, 1'b1, 4'b0011, 32'h1122_3344);   // bank 2, word 4
      drv1(1'b1, 12'h048, 1'b1, 4'b0110, 32'hAABB_CCDD);
      #1;
      chk("R5", "both stores ready", 32'({p0_ready, p1_ready}), 32'h3);
      step();
      idle();
      chk("R8", "no rvalid for store p0", 32'(p0_rvalid), 32'd0);
      chk("R8", "no rvalid for store p1", 32'(p1_rvalid), 32'd0);
      step();
      drv0(1'b1, 12'h048, 1'b0, 4'hF, '0);
      step();
      idle();
      chk("R5", "merged word", p0_rdata, {pre(2, 4)[31:24], 8'hBB, 8'hCC, 8'h44});
      step();
   endtask

   task automatic t_read_old_write();
      drv0(1'b1, 12'h05C, 1'b0, 4'hF, '0);               // bank 3, word 5
      drv1(1'b1, 12'h05C, 1'b1, 4'hF, 32'hCAFE_F00D);
      #1;
      chk("R6", "load+store ready", 32'({p0_ready, p1_ready}), 32'h3);
      step();
      idle();
      chk("R6", "old data seen", p0_rdata, pre(3, 5));
      step();
      drv1(1'b1, 12'h05C, 1'b0, 4'hF, '0);
      step();
      idle();
      chk("R6", "store landed", p1_rdata, 32'hCAFE_F00D);
      step();
   endtask

   task automatic t_raw();
      drv0(1'b1, 12'h060, 1'b1, 4'hF, 32'h0123_4567);   // store bank 0, word 6
      step();
      drv0(1'b1, 12'h070, 1'b0, 4'hF, '0);               // load bank 0, word 7
      drv1(1'b1, 12'h064, 1'b0, 4'hF, '0);               // load bank 1, word 6
      #1;
      chk("R7", "load after store held", 32'(p0_ready), 32'd0);
      chk("R7", "other bank load free", 32'(p1_ready), 32'd1);
      step();
      drv1(1'b0, '0, 1'b0, '0, '0);
      chk("R7", "other bank data", p1_rdata, pre(1, 6));
      chk("R7", "held load no rvalid", 32'(p0_rvalid), 32'd0);
      #1;
      chk("R7", "held load granted after one cycle", 32'(p0_ready), 32'd1);
      step();
      idle();
      chk("R7", "held load data", p0_rdata, pre(0, 7));
      step();
      drv0(1'b1, 12'h060, 1'b0, 4'hF, '0);
      step();
      idle();
      chk("R7", "stored word", p0_rdata, 32'h0123_4567);
      step();
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_diff_banks();
      t_conflict();
      t_same_word_reads();
      t_merge_writes();
      t_read_old_write();
      t_raw();
      finish_run();
   end
endmodule